// File: doc/BRIEF.md
# Shared-Memory Bank Conflict Arbiter

This block schedules one warp-wide shared-memory read across a banked scratchpad. A request carries 32 lanes, each with an active flag and a byte address. Every address becomes a word index, and the low bits of that word index pick one of 32 banks, each one word (4 bytes) wide. Lanes that ask for the same word are served together by one bank read that is broadcast to all of them. Lanes that ask for different words in the same bank are spread over successive cycles.

The request enters through a valid/ready handshake. On acceptance the block computes the serialization factor: the largest number of distinct words that any single bank must supply. In each following cycle it drives a lane grant vector, plus an enable and a word index for every bank. A done pulse marks the last service cycle. The number of service cycles equals the serialization factor, with a minimum of one.

Top module: `smem_bank_arbiter`

## Requirements
- R1: A lane's word index is address bits [31:2] and its bank is word index bits [4:0] (bank = floor(addr/4) mod 32). In a service cycle a granted lane's bank has its bit set in `bank_en_o`, and field b of `bank_word_o` (bits [b*30 +: 30]) equals that lane's word index.
- R2: All active lanes that request the same word are granted in the same cycle (broadcast), so they add no cycle.
- R3: Distinct words in one bank are served in separate cycles, in ascending order of the lowest lane that requests each word.
- R4: The number of service cycles equals S, where S is the largest count of distinct active words on any one bank; 32 distinct words all on bank 0 give S = 32.
- R5: 32 lanes reading 32 consecutive words complete in one cycle with S = 1.
- R6: Inactive lanes are never granted and do not count toward S. Every active lane is granted exactly once.
- R7: A request with no active lanes completes in one cycle with an all-zero grant and S = 0.
- R8: `sfactor_o` takes the new S in the cycle after acceptance and holds it until the next request is accepted.
- R9: `done_o` is high for exactly one cycle, the final service cycle. `req_ready_o` is low from the cycle after acceptance through the done cycle and high again afterwards.
- R10: After reset `req_ready_o` is 1, and `done_o`, `grant_o`, `bank_en_o` and `sfactor_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle; a request can be accepted |
| req_active_i | input | 32 | Per-lane active flag |
| req_addr_i | input | 1024 | Per-lane byte address, lane l at bits [l*32 +: 32] |
| grant_o | output | 32 | Lanes served in this cycle |
| bank_en_o | output | 32 | Banks read in this cycle |
| bank_word_o | output | 960 | Word index read by each bank, bank b at [b*30 +: 30] |
| done_o | output | 1 | Final service cycle of the request |
| sfactor_o | output | 6 | Serialization factor of the current or last request |

## Verification
The hardest situation to reach from the ports is a bank that holds several distinct words, each wanted by more than one lane, with the requesting lanes interleaved so that the lowest-lane order differs from word order. A directed request places a high word on lane 0, a lower word on lane 1 and the first word again on lane 2, so the bench can check the merge and the ordering cycle by cycle. Table vectors with strides of 0, 2, 8, 64 and 128 bytes cover broadcast, partial conflicts and the worst case of 32 distinct words on one bank.

// File: rtl/smem_arb_pkg.sv
package smem_arb_pkg;
  localparam int unsigned DEF_LANES      = 32;
  localparam int unsigned DEF_BANKS      = 32;
  localparam int unsigned DEF_ADDR_W     = 32;
  localparam int unsigned DEF_WORD_BYTES = 4;
endpackage

// File: rtl/smem_arb_scount.sv
// Serialization factor: max distinct active words per bank.
module smem_arb_scount #(
  parameter int unsigned LANES  = 32,
  parameter int unsigned BANKS  = 32,
  parameter int unsigned WORD_W = 30,
  parameter int unsigned S_W    = 6
) (
  input  logic [LANES-1:0]        act_i,
  input  logic [LANES*WORD_W-1:0] word_i,
  output logic [S_W-1:0]          s_o
);
  localparam int unsigned BANK_W = $clog2(BANKS);

  logic [LANES-1:0] leader;
  logic [S_W-1:0]   cnt [BANKS];

  // a lane leads its word if no lower active lane wants the same word
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      leader[l] = act_i[l];
      for (int j = 0; j < l; j++) begin
        if (act_i[j] && word_i[j*WORD_W +: WORD_W] == word_i[l*WORD_W +: WORD_W])
          leader[l] = 1'b0;
      end
    end
  end

  always_comb begin
    logic [BANK_W-1:0] bk;
    for (int b = 0; b < BANKS; b++) cnt[b] = '0;
    for (int l = 0; l < LANES; l++) begin
      bk = word_i[l*WORD_W +: BANK_W];
      if (leader[l]) cnt[bk] = cnt[bk] + S_W'(1);
    end
    s_o = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (cnt[b] > s_o) s_o = cnt[b];
    end
  end
endmodule

// File: rtl/smem_arb_pick.sv
// Per-cycle selection: each bank serves the word of its lowest pending lane.
module smem_arb_pick #(
  parameter int unsigned LANES  = 32,
  parameter int unsigned BANKS  = 32,
  parameter int unsigned WORD_W = 30
) (
  input  logic [LANES-1:0]        pend_i,
  input  logic [LANES*WORD_W-1:0] word_i,
  output logic [LANES-1:0]        grant_o,
  output logic [BANKS-1:0]        bank_en_o,
  output logic [BANKS*WORD_W-1:0] bank_word_o
);
  localparam int unsigned BANK_W = $clog2(BANKS);

  // descending scan: lowest pending lane overwrites last
  always_comb begin
    logic [BANK_W-1:0] bk;
    bank_en_o   = '0;
    bank_word_o = '0;
    for (int l = LANES-1; l >= 0; l--) begin
      bk = word_i[l*WORD_W +: BANK_W];
      if (pend_i[l]) begin
        bank_en_o[bk] = 1'b1;
        bank_word_o[int'(bk)*WORD_W +: WORD_W] = word_i[l*WORD_W +: WORD_W];
      end
    end
  end

  // broadcast: every pending lane on the selected word is served
  always_comb begin
    logic [BANK_W-1:0] bk;
    for (int l = 0; l < LANES; l++) begin
      bk = word_i[l*WORD_W +: BANK_W];
      grant_o[l] = pend_i[l] &&
                   (bank_word_o[int'(bk)*WORD_W +: WORD_W] == word_i[l*WORD_W +: WORD_W]);
    end
  end
endmodule

// File: rtl/smem_bank_arbiter.sv
module smem_bank_arbiter
  import smem_arb_pkg::*;
#(
  parameter int unsigned LANES      = DEF_LANES,
  parameter int unsigned BANKS      = DEF_BANKS,
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned WORD_BYTES = DEF_WORD_BYTES,
  localparam int unsigned OFF_W     = $clog2(WORD_BYTES),
  localparam int unsigned WORD_W    = ADDR_W - OFF_W,
  localparam int unsigned S_W       = $clog2(LANES + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  output logic                     req_ready_o,
  input  logic [LANES-1:0]         req_active_i,
  input  logic [LANES*ADDR_W-1:0]  req_addr_i,
  output logic [LANES-1:0]         grant_o,
  output logic [BANKS-1:0]         bank_en_o,
  output logic [BANKS*WORD_W-1:0]  bank_word_o,
  output logic                     done_o,
  output logic [S_W-1:0]           sfactor_o
);
  logic                    busy_q;
  logic [LANES-1:0]        pend_q;
  logic [LANES*WORD_W-1:0] word_in, word_q;
  logic [S_W-1:0]          s_new, s_q;
  logic [S_W-1:0]          svc_cnt_q;
  logic [LANES-1:0]        grant_raw;
  logic                    accept;

  for (genvar l = 0; l < LANES; l++) begin : g_word
    assign word_in[l*WORD_W +: WORD_W] = req_addr_i[l*ADDR_W + OFF_W +: WORD_W];
  end

  smem_arb_scount #(.LANES(LANES), .BANKS(BANKS), .WORD_W(WORD_W), .S_W(S_W)) i_scount (
    .act_i  (req_active_i),
    .word_i (word_in),
    .s_o    (s_new)
  );

  smem_arb_pick #(.LANES(LANES), .BANKS(BANKS), .WORD_W(WORD_W)) i_pick (
    .pend_i      (pend_q),
    .word_i      (word_q),
    .grant_o     (grant_raw),
    .bank_en_o   (bank_en_o),
    .bank_word_o (bank_word_o)
  );

  assign accept      = req_valid_i && !busy_q;
  assign req_ready_o = !busy_q;
  assign grant_o     = busy_q ? grant_raw : '0;
  assign done_o      = busy_q && ((pend_q & ~grant_raw) == '0);
  assign sfactor_o   = s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      pend_q    <= '0;
      word_q    <= '0;
      s_q       <= '0;
      svc_cnt_q <= '0;
    end else if (accept) begin
      busy_q    <= 1'b1;
      pend_q    <= req_active_i;
      word_q    <= word_in;
      s_q       <= s_new;
      svc_cnt_q <= '0;
    end else if (busy_q) begin
      pend_q    <= pend_q & ~grant_raw;
      svc_cnt_q <= svc_cnt_q + S_W'(1);
      if (done_o) busy_q <= 1'b0;
    end
  end

  // R4
  cycles_match_s_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (svc_cnt_q + S_W'(1)) == ((s_q == '0) ? S_W'(1) : s_q));

  // R6
  grant_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (grant_o & ~pend_q) == '0);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (grant_o == '0 && bank_en_o == '0 && !done_o));

  // R8
  sfactor_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> $stable(sfactor_o));
endmodule

// File: tb/test_smem_bank_arbiter.sv
module test_smem_bank_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 32, BANKS = 32, WORD_W = 30;

  typedef struct packed {
    logic [31:0] stride;
    logic [31:0] base;
    logic [31:0] mask;
    logic [31:0] exp_s;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{32'd4,   32'h0,   32'hFFFF_FFFF, 32'd1},   // R5 consecutive
    '{32'd128, 32'h0,   32'hFFFF_FFFF, 32'd32},  // R4 all on bank 0
    '{32'd0,   32'h40,  32'hFFFF_FFFF, 32'd1},   // R2 same word
    '{32'd8,   32'h0,   32'hFFFF_FFFF, 32'd2},   // two words per even bank
    '{32'd4,   32'h0,   32'h0,         32'd0},   // R7 empty
    '{32'd128, 32'h0,   32'h0000_000F, 32'd4},   // R6 masked lanes
    '{32'd12,  32'h100, 32'hFFFF_FFFF, 32'd1},   // stride coprime with banks
    '{32'd64,  32'h0,   32'hFFFF_FFFF, 32'd16},  // banks 0 and 16
    '{32'd2,   32'h0,   32'hFFFF_FFFF, 32'd1}    // R2 pairs share a word
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [LANES-1:0] req_active = '0;
  logic [LANES*32-1:0] req_addr = '0;
  logic [LANES-1:0] grant;
  logic [BANKS-1:0] bank_en;
  logic [BANKS*WORD_W-1:0] bank_word;
  logic done;
  logic [5:0] sfactor;

  int checks = 0, errors = 0;
  logic [31:0] addr_t [LANES];
  logic [31:0] act_t;
  logic [31:0] glog [64];
  logic [29:0] bw0log [64];
  int last_cycles;

  always #(CLK_PERIOD/2) clk = ~clk;

  smem_bank_arbiter i_smem_bank_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_active_i(req_active), .req_addr_i(req_addr), .grant_o(grant),
    .bank_en_o(bank_en), .bank_word_o(bank_word), .done_o(done), .sfactor_o(sfactor)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_req(input int exp_s, input string tag);
    int cycles;
    logic [31:0] served;
    bit fin, ready_bad, map_bad, dup_bad;
    int exp_cyc;
    @(negedge clk);
    for (int l = 0; l < LANES; l++) req_addr[l*32 +: 32] = addr_t[l];
    req_active = act_t;
    req_valid = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(sfactor == 6'(exp_s), {tag, " R4/R8 sfactor"}, sfactor, exp_s);
    cycles = 0; served = '0; fin = 0; ready_bad = 0; map_bad = 0; dup_bad = 0;
    while (!fin && cycles < 60) begin
      cycles++;
      glog[cycles] = grant;
      bw0log[cycles] = bank_word[0 +: WORD_W];
      if (req_ready) ready_bad = 1;
      for (int l = 0; l < LANES; l++) begin
        if (grant[l]) begin
          if (!act_t[l] || served[l]) dup_bad = 1;
          if (!bank_en[addr_t[l][6:2]] ||
              bank_word[int'(addr_t[l][6:2])*WORD_W +: WORD_W] != addr_t[l][31:2]) map_bad = 1;
          served[l] = 1'b1;
        end
      end
      if (done) fin = 1;
      else @(negedge clk);
    end
    last_cycles = cycles;
    exp_cyc = (exp_s == 0) ? 1 : exp_s;
    chk(cycles == exp_cyc, {tag, " R4 service cycles"}, cycles, exp_cyc);
    chk(served == act_t, {tag, " R6 each active lane once"}, served, act_t);
    chk(!dup_bad, {tag, " R6 no inactive/duplicate grant"}, dup_bad, 0);
    chk(!map_bad, {tag, " R1 bank/word mapping"}, map_bad, 0);
    chk(!ready_bad, {tag, " R9 ready low in service"}, ready_bad, 0);
    @(negedge clk);
    chk(!done && req_ready, {tag, " R9 done pulse ends, ready back"}, {done, req_ready}, 1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(req_ready == 1, "R10 ready", req_ready, 1);
    chk(done == 0 && grant == '0 && bank_en == '0, "R10 outputs idle", {done, grant}, 0);
    chk(sfactor == 0, "R10 sfactor", sfactor, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      for (int l = 0; l < LANES; l++) addr_t[l] = VECS[v].base + VECS[v].stride * l;
      act_t = VECS[v].mask;
      run_req(int'(VECS[v].exp_s), $sformatf("vec%0d", v));
    end

    // R3 ordering: lane0 word 32, lane1 word 0, lane2 word 32, lane3 word 64; all bank 0
    for (int l = 0; l < LANES; l++) addr_t[l] = 32'h0;
    addr_t[0] = 32'd128; addr_t[1] = 32'd0; addr_t[2] = 32'd130; addr_t[3] = 32'd256;
    act_t = 32'h0000_000F;
    run_req(3, "order");
    chk(glog[1] == 32'h5, "R3/R2 cycle1 lanes 0,2", glog[1], 5);
    chk(bw0log[1] == 30'd32, "R3 cycle1 word", bw0log[1], 32);
    chk(glog[2] == 32'h2, "R3 cycle2 lane 1", glog[2], 2);
    chk(bw0log[2] == 30'd0, "R3 cycle2 word", bw0log[2], 0);
    chk(glog[3] == 32'h8, "R3 cycle3 lane 3", glog[3], 8);

    // R8 hold while idle, with valid low
    for (int l = 0; l < LANES; l++) addr_t[l] = 32'd128 * l;
    act_t = 32'hFFFF_FFFF;
    run_req(32, "hold");
    repeat (4) @(negedge clk);
    chk(sfactor == 6'd32, "R8 sfactor held while idle", sfactor, 32);
    chk(grant == '0 && bank_en == '0, "R10 idle after request", grant, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule